// File: doc/BRIEF.md
# Execute Packet Dispatcher

The dispatcher sits between instruction fetch and the functional units of an explicitly parallel processor. It takes in fetch packets of eight 32-bit instruction words. It cuts each packet into execute packets using a chaining bit carried in every word, and it issues one execute packet per cycle. Each word of the issuing group is steered to the functional-unit slot named by its unit field, and that slot's valid bit is raised. The hardware does no dependency analysis. The compiler has already encoded the parallelism in the instruction stream, so the only check the block makes is that no two words in one group claim the same unit.

A fetch packet is accepted into a single holding register and is presented from the following cycle on. Fetch is throttled with a ready output. That output stays low while the held packet still contains execute packets beyond the one being issued. It rises in the cycle that the final group leaves, so the next packet can follow with no bubble. A downstream stall freezes the presented group and the issue position.

Top module: `exec_packet_dispatch`

## Requirements
- R1: After reset, `fp_ready` is 1 and both `slot_valid` and `conflict_err` are 0.
- R2: Bit 0 of each word is its chaining bit. The group issued in a cycle runs from the first word not yet issued up to and including the first word whose bit 0 is 0. Words leave in increasing word order, one group per unstalled cycle.
- R3: For chaining bits 0,1,1,0,1,1,0 on words 0 to 6, the groups are {0}, {1,2,3}, {4,5,6} and then {7}, in four consecutive cycles.
- R4: A group never extends past word 7, whatever word 7's chaining bit is. The next fetch packet always starts a new group at its word 0.
- R5: Bits [3:1] of a word give its unit number u (0 to 7). That word appears on `slot_instr[32*u+31:32*u]` with `slot_valid[u]`=1. Slots of units not named in the group show `slot_valid`=0.
- R6: If two or more words in the presented group have the same unit number, `conflict_err` is 1 for as long as that group is presented, and the lowest-numbered word wins the slot. Otherwise `conflict_err` is 0.
- R7: `fp_ready` is 1 when no packet is held, or when the presented group is the last of its packet and `stall_in` is 0. Otherwise it is 0.
- R8: While `stall_in` is 1, the presented group, its slot contents and the issue position stay unchanged. A fetch packet offered during that time is not taken.
- R9: A packet accepted at a clock edge is presented from the next cycle. A packet offered in the cycle in which the previous packet's last group issues is presented in the very next cycle.
- R10: With all chaining bits 0, a packet takes eight cycles, one word each. With all bits 1, it leaves in one cycle as a single eight-word group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fp_valid | input | 1 | A fetch packet is offered on `fp_data` |
| fp_data | input | 256 | Fetch packet; word i occupies bits [32*i+31:32*i] |
| fp_ready | output | 1 | Block takes the offered packet at this edge |
| stall_in | input | 1 | Downstream stall; freeze the presented group |
| slot_valid | output | 8 | Per-unit valid of the presented group |
| slot_instr | output | 256 | Per-unit instruction word; unit u at bits [32*u+31:32*u] |
| conflict_err | output | 1 | Presented group names one unit more than once |

## Verification
Two events can fall in the same cycle: the issue of a packet's final group and the acceptance of the next fetch packet. The bench provokes this by offering a new packet exactly in the last-group cycle. It judges the result by requiring `fp_ready` high in that cycle and the new packet's first group on the slots in the next cycle, with no idle cycle between them. The opposite case is also covered: a stall in that same last-group cycle, with a packet on offer. Here `fp_ready` must read low, and after the stall is released the old group must still be presented, which shows the offered packet was not taken.

// File: rtl/epd_pkg.sv
package epd_pkg;
  localparam int EPD_WORDS    = 8;   // instruction words per fetch packet
  localparam int EPD_IW       = 32;  // instruction width
  localparam int EPD_UFW      = 3;   // unit-select field width
  localparam int EPD_UNIT_LSB = 1;   // lowest bit of the unit-select field
  localparam int EPD_CHAIN    = 0;   // chaining bit position
endpackage

// File: rtl/epd_rst_sync.sv
module epd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/epd_boundary.sv
// Finds the words of the group that starts at the issue position.
module epd_boundary #(
  parameter int WORDS = epd_pkg::EPD_WORDS,
  parameter int PW    = $clog2(WORDS)
) (
  input  logic             held,
  input  logic [PW-1:0]    ptr,
  input  logic [WORDS-1:0] chain,
  output logic [WORDS-1:0] member,
  output logic [PW-1:0]    end_idx,
  output logic             is_last
);
  logic [WORDS-1:0] eff_chain;
  logic             run;

  // the final word always closes its group
  assign eff_chain = {1'b0, chain[WORDS-2:0]};

  always_comb begin
    run     = 1'b0;
    member  = '0;
    end_idx = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (PW'(i) == ptr) run = held;
      member[i] = run;
      if (run) end_idx = PW'(i);
      if (!eff_chain[i]) run = 1'b0;
    end
  end

  assign is_last = member[WORDS-1];
endmodule

// File: rtl/epd_router.sv
// Steers group members to unit slots and flags a doubly claimed unit.
module epd_router #(
  parameter int WORDS    = epd_pkg::EPD_WORDS,
  parameter int IW       = epd_pkg::EPD_IW,
  parameter int UFW      = epd_pkg::EPD_UFW,
  parameter int UNIT_LSB = epd_pkg::EPD_UNIT_LSB,
  parameter int UNITS    = 1 << UFW
) (
  input  logic [WORDS-1:0][IW-1:0] words,
  input  logic [WORDS-1:0]         member,
  output logic [UNITS-1:0]         slot_valid,
  output logic [UNITS-1:0][IW-1:0] slot_instr,
  output logic                     conflict
);
  logic [UFW-1:0] unit_sel;

  always_comb begin
    slot_valid = '0;
    slot_instr = '0;
    conflict   = 1'b0;
    unit_sel   = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (member[i]) begin
        unit_sel = words[i][UNIT_LSB +: UFW];
        if (slot_valid[unit_sel]) begin
          conflict = 1'b1;
        end else begin
          slot_valid[unit_sel] = 1'b1;
          slot_instr[unit_sel] = words[i];
        end
      end
    end
  end
endmodule

// File: rtl/epd_fp_buffer.sv
// Holds one fetch packet and the issue position within it.
module epd_fp_buffer #(
  parameter int WORDS = epd_pkg::EPD_WORDS,
  parameter int IW    = epd_pkg::EPD_IW,
  parameter int PW    = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fp_valid,
  input  logic [WORDS*IW-1:0] fp_data,
  input  logic                stall,
  input  logic                is_last,
  input  logic [PW-1:0]       end_idx,
  output logic                fp_ready,
  output logic                held,
  output logic [PW-1:0]       ptr,
  output logic [WORDS*IW-1:0] pkt
);
  logic                held_q, held_d;
  logic [PW-1:0]       ptr_q, ptr_d;
  logic [WORDS*IW-1:0] pkt_q;
  logic                accept;
  logic                pkt_en;

  assign fp_ready = !held_q || (is_last && !stall);
  assign accept   = fp_valid && fp_ready;
  assign pkt_en   = accept;

  always_comb begin
    held_d = held_q;
    ptr_d  = ptr_q;
    if (accept) begin
      held_d = 1'b1;
      ptr_d  = '0;
    end else if (held_q && !stall) begin
      if (is_last) held_d = 1'b0;
      else         ptr_d  = end_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      held_q <= held_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pkt_q <= '0;
    else if (pkt_en) pkt_q <= fp_data;
  end

  assign held = held_q;
  assign ptr  = ptr_q;
  assign pkt  = pkt_q;

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && stall) |=> (held_q && $stable(ptr_q) && $stable(pkt_q)));

  // R2
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !stall && !is_last) |=> (held_q && ptr_q > $past(ptr_q)));
endmodule

// File: rtl/exec_packet_dispatch.sv
module exec_packet_dispatch #(
  parameter int WORDS    = epd_pkg::EPD_WORDS,
  parameter int IW       = epd_pkg::EPD_IW,
  parameter int UFW      = epd_pkg::EPD_UFW,
  parameter int UNIT_LSB = epd_pkg::EPD_UNIT_LSB,
  parameter int CHAIN    = epd_pkg::EPD_CHAIN,
  parameter int UNITS    = 1 << UFW,
  parameter int PW       = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fp_valid,
  input  logic [WORDS*IW-1:0] fp_data,
  output logic                fp_ready,
  input  logic                stall_in,
  output logic [UNITS-1:0]    slot_valid,
  output logic [UNITS*IW-1:0] slot_instr,
  output logic                conflict_err
);
  logic                    srst_n;
  logic                    held;
  logic [PW-1:0]           ptr;
  logic [WORDS*IW-1:0]     pkt;
  logic [WORDS-1:0][IW-1:0] words;
  logic [WORDS-1:0]        chain;
  logic [WORDS-1:0]        member;
  logic [PW-1:0]           end_idx;
  logic                    is_last;
  logic [UNITS-1:0]        rt_valid;
  logic [UNITS-1:0][IW-1:0] rt_instr;
  logic                    rt_conflict;

  epd_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  epd_fp_buffer #(.WORDS(WORDS), .IW(IW), .PW(PW)) u_buf (
    .clk      (clk),
    .rst_n    (srst_n),
    .fp_valid (fp_valid),
    .fp_data  (fp_data),
    .stall    (stall_in),
    .is_last  (is_last),
    .end_idx  (end_idx),
    .fp_ready (fp_ready),
    .held     (held),
    .ptr      (ptr),
    .pkt      (pkt)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = pkt[w*IW +: IW];
    assign chain[w] = pkt[w*IW + CHAIN];
  end

  epd_boundary #(.WORDS(WORDS), .PW(PW)) u_bnd (
    .held    (held),
    .ptr     (ptr),
    .chain   (chain),
    .member  (member),
    .end_idx (end_idx),
    .is_last (is_last)
  );

  epd_router #(
    .WORDS(WORDS), .IW(IW), .UFW(UFW), .UNIT_LSB(UNIT_LSB), .UNITS(UNITS)
  ) u_rt (
    .words      (words),
    .member     (member),
    .slot_valid (rt_valid),
    .slot_instr (rt_instr),
    .conflict   (rt_conflict)
  );

  assign slot_valid   = rt_valid;
  assign slot_instr   = rt_instr;
  assign conflict_err = rt_conflict;

  // R9
  load_present_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fp_valid && fp_ready) |=> (slot_valid != '0));

  // R6
  count_match_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (held && !conflict_err) |-> ($countones(slot_valid) == $countones(member)));

  // R6
  conflict_fewer_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (held && conflict_err) |-> ($countones(slot_valid) < $countones(member)));

  // R8
  stall_out_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (held && stall_in) |=> ($stable(slot_valid) && $stable(slot_instr) && !$past(fp_ready)));

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (held && is_last && !stall_in && !fp_valid) |=> (slot_valid == '0 && fp_ready));

  for (genvar u = 0; u < UNITS; u++) begin : g_slot_chk
    // R5
    unit_match_chk: assert property (@(posedge clk) disable iff (!srst_n)
      slot_valid[u] |-> (slot_instr[u*IW + UNIT_LSB +: UFW] == UFW'(u)));
  end
endmodule

// File: tb/exec_packet_dispatch_test.sv
`timescale 1ns/1ps
module exec_packet_dispatch_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         fp_valid;
  logic [255:0] fp_data;
  logic         fp_ready;
  logic         stall_in;
  logic [7:0]   slot_valid;
  logic [255:0] slot_instr;
  logic         conflict_err;
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  exec_packet_dispatch uut (
    .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_data(fp_data),
    .fp_ready(fp_ready), .stall_in(stall_in), .slot_valid(slot_valid),
    .slot_instr(slot_instr), .conflict_err(conflict_err)
  );

  task automatic chk(input logic [255:0] act, input logic [255:0] exp,
                     input string rq, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // word layout: tag in [31:4], unit in [3:1], chaining bit in [0]
  function automatic logic [255:0] mkpkt(input logic [7:0] marks,
                                         input logic [23:0] units,
                                         input logic [7:0] seed);
    logic [255:0] p;
    p = '0;
    for (int i = 0; i < 8; i++)
      p[i*32 +: 32] = {12'hC3A, seed, 8'(i), units[i*3 +: 3], marks[i]};
    return p;
  endfunction

  task automatic model_ep(input logic [255:0] pkt, input int start,
                          output int stop, output logic [7:0] ev,
                          output logic [255:0] ed, output logic err);
    stop = start;
    while (stop < 7 && pkt[stop*32] == 1'b1) stop++;
    ev = '0; ed = '0; err = 1'b0;
    for (int i = start; i <= stop; i++) begin
      automatic int u = int'(pkt[i*32+1 +: 3]);
      if (ev[u]) err = 1'b1;
      else begin
        ev[u] = 1'b1;
        ed[u*32 +: 32] = pkt[i*32 +: 32];
      end
    end
  endtask

  task automatic present(input logic [255:0] pkt);
    @(negedge clk);
    stall_in = 1'b0;
    fp_valid = 1'b1;
    fp_data  = pkt;
    #1;
    chk(fp_ready, 1, "R7", "ready when idle");
    chk(slot_valid, 0, "R7", "idle slots");
  endtask

  task automatic run_packet(input logic [255:0] pkt, input bit preloaded,
                            input bit follow, input logic [255:0] nxt,
                            input string rq);
    int start;
    int stop;
    logic [7:0] ev;
    logic [255:0] ed;
    logic err;
    bit last;
    if (!preloaded) present(pkt);
    start = 0;
    while (start < 8) begin
      model_ep(pkt, start, stop, ev, ed, err);
      last = (stop == 7);
      @(negedge clk);
      stall_in = 1'b0;
      fp_valid = last && follow;
      fp_data  = nxt;
      #1;
      chk(slot_valid, ev, rq, "slot valid (R2/R5)");
      for (int u = 0; u < 8; u++)
        if (ev[u]) chk(slot_instr[u*32 +: 32], ed[u*32 +: 32], "R5", "slot word");
      chk(conflict_err, err, "R6", "conflict flag");
      chk(fp_ready, last, "R7", "fetch ready");
      start = stop + 1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fp_valid = 1'b0; stall_in = 1'b0; fp_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(fp_ready, 1, "R1", "ready in reset");
    chk(slot_valid, 0, "R1", "valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(fp_ready, 1, "R1", "ready after reset");
    chk(slot_valid, 0, "R1", "valid after reset");
    chk(conflict_err, 0, "R1", "conflict after reset");
  endtask

  task automatic t_example();
    logic [255:0] p;
    logic [7:0] exp_v [4];
    p = mkpkt(8'b0011_0110, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h11);
    exp_v[0] = 8'h01; exp_v[1] = 8'h0E; exp_v[2] = 8'h70; exp_v[3] = 8'h80;
    present(p);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      fp_valid = 1'b0;
      #1;
      chk(slot_valid, exp_v[c], "R3", "group per cycle");
    end
  endtask

  task automatic t_stall();
    logic [255:0] p;
    logic [255:0] q;
    p = mkpkt(8'b0111_1101, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h55);
    q = mkpkt(8'h00, 24'h0, 8'h66);
    present(p);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      fp_valid = 1'b0; stall_in = 1'b1;
      #1;
      chk(slot_valid, 8'h03, "R8", "held group");
      chk(slot_instr[32 +: 32], p[32 +: 32], "R8", "held word");
      chk(fp_ready, 0, "R8", "ready during stall");
    end
    @(negedge clk);
    stall_in = 1'b0;
    #1;
    chk(slot_valid, 8'h03, "R8", "group after stall");
    @(negedge clk);
    stall_in = 1'b1; fp_valid = 1'b1; fp_data = q;
    #1;
    chk(slot_valid, 8'hFC, "R8", "last group");
    chk(fp_ready, 0, "R7", "ready low stalled last");
    @(negedge clk);
    stall_in = 1'b0; fp_valid = 1'b0;
    #1;
    chk(slot_valid, 8'hFC, "R8", "offer ignored during stall");
    chk(slot_instr[7*32 +: 32], p[7*32 +: 32], "R8", "old word kept");
    chk(fp_ready, 1, "R7", "ready on unstalled last");
    @(negedge clk);
    #1;
    chk(slot_valid, 0, "R7", "drained");
  endtask

  initial begin
    logic [255:0] pa;
    logic [255:0] pb;
    t_reset();
    t_example();
    // R2 R10: every group a single word, units repeat across groups
    run_packet(mkpkt(8'h00, {3'd1,3'd1,3'd2,3'd2,3'd3,3'd3,3'd0,3'd0}, 8'h21), 0, 0, '0, "R10");
    // R4 R10: fully chained, word 7 chaining bit set, next packet starts fresh
    pa = mkpkt(8'hFF, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 8'h31);
    pb = mkpkt(8'b0000_0110, {3'd6,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h32);
    run_packet(pa, 0, 1, pb, "R4");
    run_packet(pb, 1, 0, '0, "R4");
    // R6: units 5,5,2 in one group, lowest word wins slot 5
    pa = mkpkt(8'b0000_0011, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd2,3'd5,3'd5}, 8'h41);
    run_packet(pa, 0, 0, '0, "R6");
    // R5: mixed unit order and group sizes
    pa = mkpkt(8'b0101_1010, {3'd2,3'd6,3'd0,3'd3,3'd7,3'd1,3'd4,3'd5}, 8'h51);
    run_packet(pa, 0, 0, '0, "R5");
    t_stall();
    // R9: back-to-back packets
    pa = mkpkt(8'b0000_0001, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h71);
    pb = mkpkt(8'b0111_1111, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 8'h72);
    run_packet(pa, 0, 1, pb, "R9");
    run_packet(pb, 1, 0, '0, "R9");
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL ALL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule